// File: doc/BRIEF.md
# Program Status and Flag Controller

This block keeps the write-permission latch and the polled status byte of a serial memory's page-program path. A write-enable command pulse arms the latch. The command receiver then delivers a program request. With the request it reports whether chip select ended the command cleanly and whether the target sector is write-protected. An accepted request starts a self-timed operation. An internal cycle counter sets its length, and a watchdog bounds it.

The status byte can be read at any time, including after a watchdog expiry:

| Bit | Meaning | Value while the operation runs |
|---|---|---|
| 7 | controller ready | 0 |
| 4 | program failure | unchanged |
| 1 | protection error | unchanged |

The error bits stay set until a clear-flags command pulse. The block only sequences the flags. Serial shifting of the byte and the array write are handled elsewhere.

Top module: `pgm_flag_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 8'h80 (ready=1, no errors) and the write-enable latch reads 0.
- R2: A write-enable pulse while ready sets the latch in the next cycle. A write-enable pulse while bit 7 is 0 is ignored.
- R3: A program request is ignored, with the status byte and latch unchanged, if the latch is 0 or if the request is flagged as not cleanly ended by select.
- R4: An accepted request drives bit 7 to 0 in the next cycle. Bit 7 stays 0 for exactly L cycles, where L is the length input (a length of 0 counts as 1), as long as L does not exceed TMO_LIMIT.
- R5: When an operation ends, the write-enable latch is cleared, and bit 7 returns to 1 in the same cycle. A successful end does not set bit 4.
- R6: If L exceeds TMO_LIMIT, the operation is cut off after TMO_LIMIT cycles. Bit 4 (program failure) is then set and the latch is cleared. With L equal to TMO_LIMIT the operation succeeds.
- R7: A valid request to a protected sector does not start, so bit 7 stays 1. The latch stays 1, and bits 1 and 4 are both set in the next cycle.
- R8: Bits 1 and 4 stay set through later operations until a clear-flags pulse, which zeroes them in the next cycle. Bits 6, 5, 3, 2 and 0 always read 0.
- R9: A program request that arrives while bit 7 is 0 is ignored and does not change the running operation's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_pulse | input | 1 | Write-enable command, one cycle |
| clrflag_pulse | input | 1 | Clear error flags command, one cycle |
| pgm_req | input | 1 | Program request from the command receiver, one cycle |
| pgm_clean_end | input | 1 | Select was released cleanly after the last data byte |
| pgm_protected | input | 1 | Target sector is write-protected |
| pgm_len | input | LEN_W | Operation duration in cycles (0 treated as 1) |
| status_byte | output | 8 | Polled flag status byte |
| wel | output | 1 | Write-enable latch |

## Verification
The checker verifies these rules on every cycle:
- the reserved status bits stay zero;
- a clean, enabled request to an unprotected sector drops bit 7 in the next cycle;
- a protected request sets bits 1 and 4 and keeps the latch;
- a request without the latch leaves bit 7 high;
- every return of bit 7 to 1 coincides with a cleared latch;
- the error bits never fall without a clear pulse.

The exact busy length and the watchdog boundary at L equal to and one above TMO_LIMIT can only be shown by the bench's scenarios. The same holds for the handling of the zero length, for the error bits outliving a later successful operation, and for requests and write-enable pulses that arrive mid-operation and must not change the outcome.

// File: rtl/pgm_flag_pkg.sv
package pgm_flag_pkg;

    localparam int SB_READY = 7;
    localparam int SB_FAIL  = 4;
    localparam int SB_PROT  = 1;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_RUN    = 2'd1,
        ACT_REFUSE = 2'd2
    } req_act_e;

    typedef struct packed {
        logic ready;
        logic fail;
        logic prot;
    } flag_set_t;

    function automatic logic [7:0] pack_status(input flag_set_t f);
        logic [7:0] b;
        b           = 8'h00;
        b[SB_READY] = f.ready;
        b[SB_FAIL]  = f.fail;
        b[SB_PROT]  = f.prot;
        return b;
    endfunction

endpackage

// File: rtl/pgm_req_gate.sv
module pgm_req_gate
    import pgm_flag_pkg::*;
(
    input  logic     req_i,
    input  logic     clean_end_i,
    input  logic     protected_i,
    input  logic     wel_i,
    input  logic     ready_i,
    output req_act_e act_o
);
    always_comb begin
        act_o = ACT_IDLE;
        if (req_i && clean_end_i && wel_i && ready_i) begin
            act_o = protected_i ? ACT_REFUSE : ACT_RUN;
        end
    end
endmodule

// File: rtl/pgm_op_timer.sv
module pgm_op_timer #(
    parameter int LEN_W     = 8,
    parameter int TMO_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             running_o,
    output logic             end_o,
    output logic             expired_o
);
    localparam int LIM_W = $clog2(TMO_LIMIT + 1);
    localparam int CNT_W = ((LEN_W > LIM_W) ? LEN_W : LIM_W) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic             over_q;
    logic             run_q;
    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] lim;

    assign lim     = CNT_W'(TMO_LIMIT);
    assign len_eff = (len_i == '0) ? CNT_W'(1) : CNT_W'(len_i);

    assign running_o = run_q;
    assign end_o     = run_q && ((cnt_q + CNT_W'(1)) == tgt_q);
    assign expired_o = end_o && over_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= '0;
            over_q <= 1'b0;
        end else if (start_i && !run_q) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            tgt_q  <= (len_eff > lim) ? lim : len_eff;
            over_q <= (len_eff > lim);
        end else if (run_q) begin
            if (end_o) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pgm_flag_regs.sv
module pgm_flag_regs
    import pgm_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wren_i,
    input  logic      clr_i,
    input  req_act_e  act_i,
    input  logic      running_i,
    input  logic      end_i,
    input  logic      expired_i,
    output logic      wel_o,
    output flag_set_t flags_o
);
    logic wel_q;
    logic fail_q;
    logic prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            fail_q <= 1'b0;
            prot_q <= 1'b0;
        end else begin
            if (end_i) begin
                wel_q <= 1'b0;
            end else if (wren_i && !running_i) begin
                wel_q <= 1'b1;
            end

            if (expired_i || act_i == ACT_REFUSE) begin
                fail_q <= 1'b1;
            end else if (clr_i) begin
                fail_q <= 1'b0;
            end

            if (act_i == ACT_REFUSE) begin
                prot_q <= 1'b1;
            end else if (clr_i) begin
                prot_q <= 1'b0;
            end
        end
    end

    assign wel_o         = wel_q;
    assign flags_o.ready = !running_i;
    assign flags_o.fail  = fail_q;
    assign flags_o.prot  = prot_q;
endmodule

// File: rtl/pgm_flag_ctrl.sv
module pgm_flag_ctrl
    import pgm_flag_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int TMO_LIMIT = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wren_pulse,
    input  logic             clrflag_pulse,
    input  logic             pgm_req,
    input  logic             pgm_clean_end,
    input  logic             pgm_protected,
    input  logic [LEN_W-1:0] pgm_len,
    output logic [7:0]       status_byte,
    output logic             wel
);
    req_act_e  act;
    logic      running;
    logic      op_end;
    logic      op_expired;
    logic      wel_int;
    flag_set_t flags;

    pgm_req_gate u_gate (
        .req_i       (pgm_req),
        .clean_end_i (pgm_clean_end),
        .protected_i (pgm_protected),
        .wel_i       (wel_int),
        .ready_i     (!running),
        .act_o       (act)
    );

    pgm_op_timer #(
        .LEN_W     (LEN_W),
        .TMO_LIMIT (TMO_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (act == ACT_RUN),
        .len_i     (pgm_len),
        .running_o (running),
        .end_o     (op_end),
        .expired_o (op_expired)
    );

    pgm_flag_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wren_i    (wren_pulse),
        .clr_i     (clrflag_pulse),
        .act_i     (act),
        .running_i (running),
        .end_i     (op_end),
        .expired_i (op_expired),
        .wel_o     (wel_int),
        .flags_o   (flags)
    );

    assign wel         = wel_int;
    assign status_byte = pack_status(flags);
endmodule

// File: rtl/pgm_flag_ctrl_chk.sv
module pgm_flag_ctrl_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wren_pulse,
    input logic             clrflag_pulse,
    input logic             pgm_req,
    input logic             pgm_clean_end,
    input logic             pgm_protected,
    input logic [LEN_W-1:0] pgm_len,
    input logic [7:0]       status_byte,
    input logic             wel
);
    logic ready;
    assign ready = status_byte[7];

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status_byte[6:5] == 2'b00) && (status_byte[3:2] == 2'b00) && !status_byte[0]);

    a_r4_start_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (ready && pgm_req && pgm_clean_end && wel && !pgm_protected) |=> !ready);

    a_r7_protect_reject: assert property (@(posedge clk) disable iff (rst)
        (ready && pgm_req && pgm_clean_end && wel && pgm_protected)
        |=> (ready && wel && status_byte[1] && status_byte[4]));

    a_r3_no_latch_no_start: assert property (@(posedge clk) disable iff (rst)
        (ready && !wel && pgm_req) |=> ready);

    a_r5_end_clears_latch: assert property (@(posedge clk) disable iff (rst)
        (!ready ##1 ready) |-> !wel);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_byte[4] && !clrflag_pulse) |=> status_byte[4]);

    a_r8_prot_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_byte[1] && !clrflag_pulse) |=> status_byte[1]);

    a_r2_latch_set: assert property (@(posedge clk) disable iff (rst)
        (ready && wren_pulse) |=> wel);
endmodule

bind pgm_flag_ctrl pgm_flag_ctrl_chk #(.LEN_W(LEN_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .wren_pulse    (wren_pulse),
    .clrflag_pulse (clrflag_pulse),
    .pgm_req       (pgm_req),
    .pgm_clean_end (pgm_clean_end),
    .pgm_protected (pgm_protected),
    .pgm_len       (pgm_len),
    .status_byte   (status_byte),
    .wel           (wel)
);

// File: tb/pgm_flag_ctrl_tb.sv
module pgm_flag_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;
    localparam int TMO_LIMIT  = 100;
    localparam int WDOG       = 50000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wren_pulse = 1'b0;
    logic             clrflag_pulse = 1'b0;
    logic             pgm_req = 1'b0;
    logic             pgm_clean_end = 1'b0;
    logic             pgm_protected = 1'b0;
    logic [LEN_W-1:0] pgm_len = '0;
    logic [7:0]       status_byte;
    logic             wel;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgm_flag_ctrl #(.LEN_W(LEN_W), .TMO_LIMIT(TMO_LIMIT)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .wren_pulse    (wren_pulse),
        .clrflag_pulse (clrflag_pulse),
        .pgm_req       (pgm_req),
        .pgm_clean_end (pgm_clean_end),
        .pgm_protected (pgm_protected),
        .pgm_len       (pgm_len),
        .status_byte   (status_byte),
        .wel           (wel)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_wren();
        wren_pulse = 1'b1; step(); wren_pulse = 1'b0;
    endtask

    task automatic pulse_clr();
        clrflag_pulse = 1'b1; step(); clrflag_pulse = 1'b0;
    endtask

    task automatic send_req(input logic clean, input logic prot, input int len);
        pgm_req = 1'b1; pgm_clean_end = clean; pgm_protected = prot;
        pgm_len = LEN_W'(len);
        step();
        pgm_req = 1'b0; pgm_clean_end = 1'b0; pgm_protected = 1'b0;
    endtask

    // count cycles until bit 7 returns to 1; optionally disturb mid-operation
    task automatic wait_ready(output int n, input bit disturb);
        n = 0;
        while (!status_byte[7] && n < 1000) begin
            if (disturb && n == 0) begin
                wren_pulse = 1'b1; pgm_req = 1'b1; pgm_clean_end = 1'b1;
                pgm_len = LEN_W'(50);
            end
            step();
            wren_pulse = 1'b0; pgm_req = 1'b0; pgm_clean_end = 1'b0;
            n++;
        end
    endtask

    task automatic t_reset();
        check("R1 status after reset", status_byte, 8'h80);
        check("R1 wel after reset", wel, 0);
    endtask

    task automatic t_ignored_requests();
        send_req(1'b1, 1'b0, 4);
        check("R3 no latch: status", status_byte, 8'h80);
        check("R3 no latch: wel", wel, 0);
        pulse_wren();
        check("R2 wel set", wel, 1);
        send_req(1'b0, 1'b0, 4);
        check("R3 unclean end: status", status_byte, 8'h80);
        check("R3 unclean end: wel", wel, 1);
    endtask

    task automatic t_program(input int len, input bit disturb, input int exp_status);
        int n;
        int exp_n;
        exp_n = (len == 0) ? 1 : ((len > TMO_LIMIT) ? TMO_LIMIT : len);
        if (!wel) pulse_wren();
        send_req(1'b1, 1'b0, len);
        check("R4 ready drops", status_byte[7], 0);
        wait_ready(n, disturb);
        check(disturb ? "R9 busy length unchanged" : "R4 busy length", n, exp_n);
        check(len > TMO_LIMIT ? "R6 status after end" : "R5 status after end",
              status_byte, exp_status);
        check(disturb ? "R2 wren while busy ignored, wel" : "R5 wel cleared", wel, 0);
    endtask

    task automatic t_protect();
        pulse_wren();
        send_req(1'b1, 1'b1, 5);
        check("R7 protected: status", status_byte, 8'h92);
        check("R7 protected: wel kept", wel, 1);
        step(); step();
        check("R8 flags sticky", status_byte, 8'h92);
        pulse_clr();
        check("R8 clear flags", status_byte, 8'h80);
        check("R8 clear keeps wel", wel, 1);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_ignored_requests();
        t_program(5, 1'b0, 8'h80);
        t_program(7, 1'b1, 8'h80);
        t_program(0, 1'b0, 8'h80);
        t_program(TMO_LIMIT, 1'b0, 8'h80);
        t_program(TMO_LIMIT + 1, 1'b0, 8'h90);
        t_program(3, 1'b0, 8'h90);
        pulse_clr();
        check("R8 clear fail", status_byte, 8'h80);
        t_protect();
        t_program(2, 1'b0, 8'h80);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule